// File: doc/BRIEF.md
# NOR Flash Buffered-Program Command Sequencer

This block turns one buffered-program request into the exact series of bus write cycles that a parallel NOR flash expects for a write-buffer program. A request gives a start word address and a word count on a single-cycle `start_i` pulse. The block then issues the following cycles in order: two unlock writes, a buffer-load command, a header word holding the count minus one, and each payload word. It finishes with a confirm command. Payload words arrive through a valid/ready stream and are written one for one at consecutive word addresses.

The write side is a plain cycle interface. In every cycle where `wr_stb_o` is high, the flash bus adapter downstream performs one write of `wr_data_o` at `wr_addr_o`. Requests with an unusable count are refused at once with a one-cycle error pulse. Polling the flash for completion is left to the caller.

The controller is a state machine with these states:

- IDLE: waits for a request.
- UNLOCK1 and UNLOCK2: the two unlock writes.
- BUFCMD: the buffer-load command.
- COUNTHDR: the count header.
- LOAD: payload writes, one per accepted beat.
- CONFIRM: the confirm command.
- DONE: a one-cycle completion pulse.
- REJECT: a one-cycle error pulse.

Its transitions are:

- IDLE→UNLOCK1 on a request with a valid count; IDLE→REJECT on a request with a bad count.
- UNLOCK1→UNLOCK2→BUFCMD→COUNTHDR→LOAD, one cycle each.
- LOAD stays in LOAD until the last beat is accepted, then moves to CONFIRM.
- CONFIRM→DONE→IDLE.
- REJECT→IDLE.

Top module: `nor_bufprog_seq`

## Requirements
- R1: After reset the block is idle: `wr_stb_o`, `in_ready_o`, `busy_o`, `done_o` and `err_o` are all low.
- R2: An accepted request first writes 0x00AA at word address 0x555, then 0x0055 at word address 0x2AA, in two consecutive cycles.
- R3: The third write of a request is data 0x0025 at the start address.
- R4: The fourth write is the word count minus one, zero-extended, at the start address.
- R5: Payload words are written in stream order at the start address, start+1, and so on up to start+count-1. Each write happens in the cycle its beat is accepted.
- R6: The last write of a request is data 0x0029 at start+count-1, the address of the last payload word.
- R7: A count of zero, or above `MAX_WORDS` (default 32), gives exactly one `err_o` pulse in the cycle after the request. There are no bus writes and `in_ready_o` is never raised.
- R8: `in_ready_o` is high only during the payload phase. A cycle with `in_valid_i` low in that phase produces no write, and exactly count beats are consumed.
- R9: `done_o` is high for exactly one clock, in the cycle right after the confirm write.
- R10: `start_i` is only taken in IDLE. A request pulse while a program is in progress changes none of the writes of the running request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request pulse, taken only when idle |
| start_addr_i | input | ADDR_W | First payload word address |
| word_count_i | input | CNT_W | Number of payload words |
| in_valid_i | input | 1 | Payload word present |
| in_data_i | input | DATA_W | Payload word |
| in_ready_o | output | 1 | Payload word taken this cycle when valid |
| wr_stb_o | output | 1 | Bus write this cycle |
| wr_addr_o | output | ADDR_W | Bus write word address |
| wr_data_o | output | DATA_W | Bus write data |
| busy_o | output | 1 | Write sequence in progress (UNLOCK1 to CONFIRM) |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle rejection pulse |

## Verification
The assertions assume that the caller holds `start_addr_i` and `word_count_i` steady only in the cycle of the request. The block copies both at that point, so later changes must be harmless. The assertions also assume that payload addresses do not wrap past the top of the address range. For this reason the stimulus draws start addresses well below the limit. It also changes `in_valid_i` and `in_data_i` freely, both in and out of the payload phase, so that stalls at random points and beats offered while `in_ready_o` is low are both covered.

// File: rtl/nor_bp_pkg.sv
package nor_bp_pkg;

    typedef enum logic [3:0] {
        S_IDLE     = 4'd0,
        S_UNLOCK1  = 4'd1,
        S_UNLOCK2  = 4'd2,
        S_BUFCMD   = 4'd3,
        S_COUNTHDR = 4'd4,
        S_LOAD     = 4'd5,
        S_CONFIRM  = 4'd6,
        S_DONE     = 4'd7,
        S_REJECT   = 4'd8
    } seq_state_t;

    localparam logic [15:0] UNLOCK_DATA_A = 16'h00AA;
    localparam logic [15:0] UNLOCK_DATA_B = 16'h0055;
    localparam logic [11:0] UNLOCK_ADR_A  = 12'h555;
    localparam logic [11:0] UNLOCK_ADR_B  = 12'h2AA;
    localparam logic [15:0] BUF_LOAD_CMD  = 16'h0025;
    localparam logic [15:0] BUF_CONF_CMD  = 16'h0029;

endpackage

// File: rtl/nor_bp_track.sv
// Request capture: running word address, last loaded address, beats left.
module nor_bp_track #(
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 8,
    parameter int MAX_WORDS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic              beat_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              count_ok_o,
    output logic              last_beat_o,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [ADDR_W-1:0] last_addr_o,
    output logic [DATA_W-1:0] hdr_word_o
);
    localparam logic [CNT_W-1:0] ONE_BEAT = CNT_W'(1);

    logic [CNT_W-1:0] remain_q;

    assign count_ok_o  = (count_i != '0) && (32'(count_i) <= MAX_WORDS);
    assign last_beat_o = (remain_q == ONE_BEAT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr_o  <= '0;
            last_addr_o <= '0;
            hdr_word_o  <= '0;
            remain_q    <= '0;
        end else if (launch_i) begin
            cur_addr_o  <= start_addr_i;
            last_addr_o <= start_addr_i;
            hdr_word_o  <= DATA_W'(count_i) - DATA_W'(1);
            remain_q    <= count_i;
        end else if (beat_i) begin
            cur_addr_o  <= cur_addr_o + ADDR_W'(1);
            last_addr_o <= cur_addr_o;
            remain_q    <= remain_q - ONE_BEAT;
        end
    end

    // R5: a beat is never taken once the requested words are used up
    p_beats_within_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        beat_i |-> (remain_q != '0));

    // R6: the word after the final beat records that beat's address
    p_last_addr_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_i && !launch_i) |=> (last_addr_o == $past(cur_addr_o)));
endmodule

// File: rtl/nor_bp_fsm.sv
// Sequencing state machine and per-state output decode.
module nor_bp_fsm
    import nor_bp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       count_ok_i,
    input  logic       in_valid_i,
    input  logic       last_beat_i,
    output seq_state_t state_o,
    output logic       launch_o,
    output logic       beat_o,
    output logic       in_ready_o,
    output logic       wr_stb_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o
);
    seq_state_t state_q, state_d;

    assign state_o = state_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start_i) state_d = count_ok_i ? S_UNLOCK1 : S_REJECT;
            S_UNLOCK1:  state_d = S_UNLOCK2;
            S_UNLOCK2:  state_d = S_BUFCMD;
            S_BUFCMD:   state_d = S_COUNTHDR;
            S_COUNTHDR: state_d = S_LOAD;
            S_LOAD:     if (in_valid_i && last_beat_i) state_d = S_CONFIRM;
            S_CONFIRM:  state_d = S_DONE;
            S_DONE:     state_d = S_IDLE;
            S_REJECT:   state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        launch_o   = 1'b0;
        beat_o     = 1'b0;
        in_ready_o = 1'b0;
        wr_stb_o   = 1'b0;
        busy_o     = 1'b0;
        done_o     = 1'b0;
        err_o      = 1'b0;
        unique case (state_q)
            S_IDLE:     launch_o = start_i && count_ok_i;
            S_UNLOCK1,
            S_UNLOCK2,
            S_BUFCMD,
            S_COUNTHDR,
            S_CONFIRM: begin
                wr_stb_o = 1'b1;
                busy_o   = 1'b1;
            end
            S_LOAD: begin
                in_ready_o = 1'b1;
                beat_o     = in_valid_i;
                wr_stb_o   = in_valid_i;
                busy_o     = 1'b1;
            end
            S_DONE:     done_o = 1'b1;
            S_REJECT:   err_o  = 1'b1;
            default: ;
        endcase
    end

    // R7: a rejection follows an idle request and nothing else
    p_reject_after_request_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_REJECT) |-> ($past(start_i) && !$past(count_ok_i)));

    // R10: a request never restarts an ongoing sequence
    p_start_ignored_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && state_q != S_CONFIRM && !(state_q == S_LOAD && in_valid_i && last_beat_i))
            |=> busy_o);
endmodule

// File: rtl/nor_bp_wmux.sv
// Write address/data selection per state.
module nor_bp_wmux
    import nor_bp_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  seq_state_t        state_i,
    input  logic [ADDR_W-1:0] cur_addr_i,
    input  logic [ADDR_W-1:0] last_addr_i,
    input  logic [DATA_W-1:0] hdr_word_i,
    input  logic [DATA_W-1:0] in_data_i,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);
    localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(UNLOCK_ADR_A);
    localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(UNLOCK_ADR_B);

    always_comb begin
        wr_addr_o = '0;
        wr_data_o = '0;
        unique case (state_i)
            S_UNLOCK1: begin
                wr_addr_o = ADR_A;
                wr_data_o = DATA_W'(UNLOCK_DATA_A);
            end
            S_UNLOCK2: begin
                wr_addr_o = ADR_B;
                wr_data_o = DATA_W'(UNLOCK_DATA_B);
            end
            S_BUFCMD: begin
                wr_addr_o = cur_addr_i;
                wr_data_o = DATA_W'(BUF_LOAD_CMD);
            end
            S_COUNTHDR: begin
                wr_addr_o = cur_addr_i;
                wr_data_o = hdr_word_i;
            end
            S_LOAD: begin
                wr_addr_o = cur_addr_i;
                wr_data_o = in_data_i;
            end
            S_CONFIRM: begin
                wr_addr_o = last_addr_i;
                wr_data_o = DATA_W'(BUF_CONF_CMD);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nor_bufprog_seq.sv
module nor_bufprog_seq
    import nor_bp_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 8,
    parameter int MAX_WORDS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [CNT_W-1:0]  word_count_i,
    input  logic              in_valid_i,
    input  logic [DATA_W-1:0] in_data_i,
    output logic              in_ready_o,
    output logic              wr_stb_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    seq_state_t        state;
    logic              launch, beat, count_ok, last_beat;
    logic [ADDR_W-1:0] cur_addr, last_addr;
    logic [DATA_W-1:0] hdr_word;

    nor_bp_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .count_ok_i (count_ok),
        .in_valid_i (in_valid_i),
        .last_beat_i(last_beat),
        .state_o    (state),
        .launch_o   (launch),
        .beat_o     (beat),
        .in_ready_o (in_ready_o),
        .wr_stb_o   (wr_stb_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .err_o      (err_o)
    );

    nor_bp_track #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CNT_W    (CNT_W),
        .MAX_WORDS(MAX_WORDS)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_i    (launch),
        .beat_i      (beat),
        .start_addr_i(start_addr_i),
        .count_i     (word_count_i),
        .count_ok_o  (count_ok),
        .last_beat_o (last_beat),
        .cur_addr_o  (cur_addr),
        .last_addr_o (last_addr),
        .hdr_word_o  (hdr_word)
    );

    nor_bp_wmux #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_wmux (
        .state_i    (state),
        .cur_addr_i (cur_addr),
        .last_addr_i(last_addr),
        .hdr_word_i (hdr_word),
        .in_data_i  (in_data_i),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o)
    );

    // R8: the stream is only opened while a sequence is running
    p_ready_only_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> busy_o);

    // R8: a stalled payload cycle writes nothing
    p_stall_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready_o && !in_valid_i) |-> !wr_stb_o);

    // R5: back-to-back payload writes step the address by one word
    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_o && in_ready_o && $past(wr_stb_o && in_ready_o))
            |-> (wr_addr_o == $past(wr_addr_o) + ADDR_W'(1)));

    // R9: completion follows a confirm write
    p_done_after_confirm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(wr_stb_o && !in_ready_o && wr_data_o == DATA_W'(BUF_CONF_CMD)));

    // R9: completion is a single-cycle pulse
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: a rejection is silent on the bus
    p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!wr_stb_o && !in_ready_o && !busy_o));
endmodule

// File: tb/tb_nor_bufprog_seq.sv
module tb_nor_bufprog_seq;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 8;
    localparam int MAXW   = 32;
    localparam int LOGN   = 128;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] start_addr_i = '0;
    logic [CNT_W-1:0]  word_count_i = '0;
    logic              in_valid_i = 1'b0;
    logic [DATA_W-1:0] in_data_i = '0;
    logic              in_ready_o, wr_stb_o, busy_o, done_o, err_o;
    logic [ADDR_W-1:0] wr_addr_o;
    logic [DATA_W-1:0] wr_data_o;

    nor_bufprog_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .MAX_WORDS(MAXW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .word_count_i(word_count_i), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
        .in_ready_o(in_ready_o), .wr_stb_o(wr_stb_o), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // write logger and event monitor
    logic [ADDR_W-1:0] log_a [LOGN];
    logic [DATA_W-1:0] log_d [LOGN];
    int log_n, beats, done_n, err_n, done_cyc, conf_cyc, ready_idle;
    logic [DATA_W-1:0] payload [MAXW];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_stb_o) begin
                if (log_n < LOGN) begin
                    log_a[log_n] = wr_addr_o;
                    log_d[log_n] = wr_data_o;
                end
                log_n = log_n + 1;
                if (!in_ready_o) conf_cyc = cyc;
            end
            if (in_valid_i && in_ready_o) beats = beats + 1;
            if (done_o) begin done_n = done_n + 1; done_cyc = cyc; end
            if (err_o) err_n = err_n + 1;
            if (in_ready_o && !busy_o) ready_idle = ready_idle + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] exp_addr(input int i, input int sa, input int cnt);
        if (i == 0) return ADDR_W'(12'h555);
        if (i == 1) return ADDR_W'(12'h2AA);
        if (i < 4)  return ADDR_W'(sa);
        if (i < 4 + cnt) return ADDR_W'(sa + i - 4);
        return ADDR_W'(sa + cnt - 1);
    endfunction

    function automatic logic [DATA_W-1:0] exp_data(input int i, input int cnt);
        if (i == 0) return 16'h00AA;
        if (i == 1) return 16'h0055;
        if (i == 2) return 16'h0025;
        if (i == 3) return DATA_W'(cnt - 1);
        if (i < 4 + cnt) return payload[i - 4];
        return 16'h0029;
    endfunction

    function automatic string req_of(input int i, input int cnt);
        if (i < 2) return "R2";
        if (i == 2) return "R3";
        if (i == 3) return "R4";
        if (i < 4 + cnt) return "R5";
        return "R6";
    endfunction

    task automatic clear_log();
        log_n = 0; beats = 0; done_n = 0; err_n = 0;
        done_cyc = -1; conf_cyc = -1; ready_idle = 0;
    endtask

    // runs one valid request; density is valid probability in percent
    task automatic run_burst(input int sa, input int cnt, input int density, input bit poke_start);
        int idx;
        int guard;
        clear_log();
        for (int k = 0; k < cnt; k++) payload[k] = DATA_W'($urandom);
        @(posedge clk); #1;
        start_i = 1'b1; start_addr_i = ADDR_W'(sa); word_count_i = CNT_W'(cnt);
        @(posedge clk); #1;
        start_i = 1'b0; start_addr_i = ADDR_W'($urandom); word_count_i = CNT_W'($urandom);
        in_valid_i = 1'b1; in_data_i = DATA_W'($urandom);  // offered before ready
        guard = 0;
        while (done_n == 0 && guard < 400) begin
            @(posedge clk); #1;
            guard++;
            idx = beats;
            // R10: a request while busy must be ignored
            start_i = poke_start && (idx == 1);
            word_count_i = CNT_W'(3);
            if (idx >= cnt) begin
                in_valid_i = 1'b0;
            end else begin
                in_valid_i = (($urandom % 100) < density);
                in_data_i  = in_valid_i ? payload[idx] : DATA_W'($urandom);
                if (!in_ready_o && in_valid_i) in_data_i = DATA_W'($urandom);
                if (!in_ready_o) in_data_i = payload[idx];
            end
        end
        start_i = 1'b0; in_valid_i = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(log_n == cnt + 5, "R5", "write count", log_n, cnt + 5);
        for (int i = 0; i < cnt + 5 && i < log_n; i++) begin
            check(log_a[i] == exp_addr(i, sa, cnt), req_of(i, cnt), "address",
                  log_a[i], exp_addr(i, sa, cnt));
            check(log_d[i] == exp_data(i, cnt), req_of(i, cnt), "data",
                  log_d[i], exp_data(i, cnt));
        end
        check(beats == cnt, "R8", "beats consumed", beats, cnt);
        check(ready_idle == 0, "R8", "ready while not busy", ready_idle, 0);
        check(done_n == 1, "R9", "done pulses", done_n, 1);
        check(done_cyc == conf_cyc + 1, "R9", "done cycle", done_cyc, conf_cyc + 1);
        check(err_n == 0, "R7", "spurious error", err_n, 0);
        check(!busy_o && !done_o, "R10", "back to idle", {busy_o, done_o}, 0);
    endtask

    task automatic run_reject(input int cnt);
        clear_log();
        @(posedge clk); #1;
        start_i = 1'b1; start_addr_i = ADDR_W'($urandom % 4096); word_count_i = CNT_W'(cnt);
        in_valid_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        in_valid_i = 1'b0;
        check(err_n == 1, "R7", "error pulses", err_n, 1);
        check(log_n == 0, "R7", "writes on reject", log_n, 0);
        check(beats == 0, "R7", "beats on reject", beats, 0);
        check(done_n == 0, "R7", "done on reject", done_n, 0);
    endtask

    initial begin
        void'($urandom(32'd7351));
        clear_log();
        repeat (3) @(posedge clk);
        #1;
        // R1: idle outputs under reset and just after release
        check({wr_stb_o, in_ready_o, busy_o, done_o, err_o} == 5'b0, "R1", "reset outputs",
              {wr_stb_o, in_ready_o, busy_o, done_o, err_o}, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check({wr_stb_o, in_ready_o, busy_o, done_o, err_o} == 5'b0, "R1", "idle outputs",
              {wr_stb_o, in_ready_o, busy_o, done_o, err_o}, 0);

        // directed corners
        run_burst(24'h000100, 1, 100, 1'b0);
        run_burst(24'h0003F0, MAXW, 100, 1'b0);
        run_burst(24'h002000, 5, 40, 1'b1);    // R10
        run_reject(0);
        run_reject(MAXW + 1);
        run_reject(255);

        // random requests
        for (int n = 0; n < 12; n++) begin
            run_burst(int'($urandom % 24'h7FFF00), 1 + int'($urandom % MAXW),
                      20 + int'($urandom % 81), n[0]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        while (cyc < 150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule